// File: doc/BRIEF.md
# Pixel Hit Timestamp Recorder

This block sits in every pixel of a timing-only pixel array. A bunch-crossing count is shared across the whole array and fed to every pixel. While the train window is open, each rising edge of the pixel's discriminator output copies the present crossing number into the next empty entry of a small local store. A one-bit flag shows that at least one hit was taken, so a pixel can be polled cheaply before anything else is read. No pulse height is kept.

After the train, a reader walks through the stored stamps with a read strobe. The oldest unread stamp is shown with a valid bit. A train-start pulse wipes the pixel before the next train begins.

Top module: `pixstamp_rec`

## Requirements
- R1: A rising edge of discIn in a cycle with trainActive high and trainStart low stores xingCount in the next free slot. Slots fill from the lowest index upward.
- R2: A discIn level that stays high for several cycles is stored only once. Another capture needs discIn to go low and then high again.
- R3: At most 4 stamps are held. A rising edge that finds all slots full is discarded and sets overflow. Overflow stays set until the next train start.
- R4: hitFlag rises in the cycle after the first stored hit and stays high until the next train start.
- R5: trainStart clears all stamps, hitFlag, overflow and the read position in the following cycle. It wins over a capture or a read in the same cycle. Asynchronous reset (rstN low) gives the same cleared state.
- R6: Rising edges of discIn while trainActive is low change neither the store, nor hitFlag, nor overflow.
- R7: stampOut shows the oldest unread stamp, so stamps come out in capture order. A readStrobe while stampValid is high moves to the next stamp in the following cycle.
- R8: stampValid is low when every stored stamp has been read or none exists. stampOut is zero while stampValid is low. A readStrobe while stampValid is low has no effect.
- R9: A capture and an accepted read in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| discIn | input | 1 | Discriminator output of the pixel |
| trainActive | input | 1 | High while the bunch train window is open |
| trainStart | input | 1 | Synchronous clear at the start of a train |
| xingCount | input | 14 | Shared bunch-crossing number |
| readStrobe | input | 1 | Advance to the next stored stamp |
| stampOut | output | 14 | Oldest unread stamp, zero when none |
| stampValid | output | 1 | stampOut holds an unread stamp |
| hitFlag | output | 1 | At least one stamp was stored this train |
| overflow | output | 1 | A hit was lost because the store was full |

## Verification
Three pairs of events can fall in the same cycle. A capture can meet a read strobe. A strobe can arrive while the store is empty or fully read. A train start can arrive together with a capture and a strobe. The bench drives each pair in one cycle, both in directed steps and in a long random stretch. A behavioural queue model predicts the outputs, and they are compared against it on every clock. The model rules are these: a strobe counts only if a stamp was unread before that cycle's capture, and a train start overrides everything else in its cycle.

// File: rtl/pixstamp_pkg.sv
package pixstamp_pkg;
  // Strobes from control to the storage datapath
  typedef struct packed {
    logic clear;    // wipe store at train start
    logic capture;  // write crossing number into the free slot
    logic advance;  // move read position forward
    logic drop;     // hit lost, store full
  } strobe_t;
endpackage

// File: rtl/pixstamp_ctrl.sv
module pixstamp_ctrl
  import pixstamp_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             discIn,
  input  logic             trainActive,
  input  logic             trainStart,
  input  logic             readStrobe,
  output strobe_t          strobes,
  output logic [CNT_W-1:0] wrIdx,
  output logic [CNT_W-1:0] rdIdx,
  output logic             stampValid,
  output logic             hitFlag,
  output logic             overflow
);
  logic             discPrev;
  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] rdPtr;
  logic             ovfQ;
  logic             riseSeen;
  logic             spaceLeft;
  logic             unread;

  always_comb begin
    riseSeen  = discIn & ~discPrev & trainActive;
    spaceLeft = fillCnt < CNT_W'(SLOTS);
    unread    = rdPtr < fillCnt;
    strobes.clear   = trainStart;
    strobes.capture = ~trainStart & riseSeen & spaceLeft;
    strobes.drop    = ~trainStart & riseSeen & ~spaceLeft;
    strobes.advance = ~trainStart & readStrobe & unread;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discPrev <= 1'b0;
      fillCnt  <= '0;
      rdPtr    <= '0;
      ovfQ     <= 1'b0;
    end else begin
      discPrev <= discIn;
      if (strobes.clear) begin
        fillCnt <= '0;
        rdPtr   <= '0;
        ovfQ    <= 1'b0;
      end else begin
        if (strobes.capture) fillCnt <= fillCnt + CNT_W'(1);
        if (strobes.advance) rdPtr   <= rdPtr + CNT_W'(1);
        if (strobes.drop)    ovfQ    <= 1'b1;
      end
    end
  end

  assign wrIdx      = fillCnt;
  assign rdIdx      = rdPtr;
  assign stampValid = unread;
  assign hitFlag    = fillCnt != '0;
  assign overflow   = ovfQ;
endmodule

// File: rtl/pixstamp_store.sv
module pixstamp_store
  import pixstamp_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int STAMP_W = 14,
  parameter int CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [CNT_W-1:0]   wrIdx,
  input  logic [CNT_W-1:0]   rdIdx,
  input  logic               stampValid,
  input  logic [STAMP_W-1:0] xingCount,
  output logic [STAMP_W-1:0] stampOut
);
  logic [STAMP_W-1:0] slotQ [SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) slotQ[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (strobes.clear) slotQ[i] <= '0;
        else if (strobes.capture && wrIdx == CNT_W'(i)) slotQ[i] <= xingCount;
      end
    end
  end

  always_comb begin
    stampOut = '0;
    for (int i = 0; i < SLOTS; i++)
      if (stampValid && rdIdx == CNT_W'(i)) stampOut = slotQ[i];
  end
endmodule

// File: rtl/pixstamp_rec.sv
module pixstamp_rec
  import pixstamp_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int STAMP_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               discIn,
  input  logic               trainActive,
  input  logic               trainStart,
  input  logic [STAMP_W-1:0] xingCount,
  input  logic               readStrobe,
  output logic [STAMP_W-1:0] stampOut,
  output logic               stampValid,
  output logic               hitFlag,
  output logic               overflow
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  strobe_t          strobes;
  logic [CNT_W-1:0] wrIdx;
  logic [CNT_W-1:0] rdIdx;

  pixstamp_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .discIn(discIn), .trainActive(trainActive),
    .trainStart(trainStart), .readStrobe(readStrobe), .strobes(strobes),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .stampValid(stampValid),
    .hitFlag(hitFlag), .overflow(overflow)
  );

  pixstamp_store #(.SLOTS(SLOTS), .STAMP_W(STAMP_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .stampValid(stampValid), .xingCount(xingCount), .stampOut(stampOut)
  );
endmodule

// File: rtl/pixstamp_chk.sv
module pixstamp_chk #(
  parameter int STAMP_W = 14
) (
  input logic               clk,
  input logic               rstN,
  input logic               trainActive,
  input logic               trainStart,
  input logic [STAMP_W-1:0] stampOut,
  input logic               stampValid,
  input logic               hitFlag,
  input logic               overflow
);
  // R5: a train start leaves the pixel empty
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    trainStart |=> (!hitFlag && !overflow && !stampValid));

  // R3: a lost hit stays flagged until the next train start
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !trainStart) |=> overflow);

  // R6: with the window closed, flag and overflow hold
  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!trainActive && !trainStart) |=> ($stable(hitFlag) && $stable(overflow)));

  // R8: an unread stamp implies a stored hit
  p_valid_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    stampValid |-> hitFlag);

  // R8: the output reads zero when nothing is unread
  p_zero_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stampValid |-> (stampOut == '0));
endmodule

bind pixstamp_rec pixstamp_chk #(.STAMP_W(STAMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .trainActive(trainActive), .trainStart(trainStart),
  .stampOut(stampOut), .stampValid(stampValid), .hitFlag(hitFlag),
  .overflow(overflow)
);

// File: tb/sim_pixstamp_rec.sv
module sim_pixstamp_rec;
  localparam int SLOTS = 4;
  localparam int SW    = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          discIn = 1'b0, trainActive = 1'b0, trainStart = 1'b0, readStrobe = 1'b0;
  logic [SW-1:0] xingCount = '0;
  logic [SW-1:0] stampOut;
  logic          stampValid, hitFlag, overflow;

  int errors = 0;
  int checks = 0;

  // reference model state
  int mStamps[$];
  int mRd = 0;
  bit mOvf = 0;
  bit mPrev = 0;
  int xcnt = 0;

  always #4 clk = ~clk;

  pixstamp_rec #(.SLOTS(SLOTS), .STAMP_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .discIn(discIn), .trainActive(trainActive),
    .trainStart(trainStart), .xingCount(xingCount), .readStrobe(readStrobe),
    .stampOut(stampOut), .stampValid(stampValid), .hitFlag(hitFlag),
    .overflow(overflow)
  );

  task automatic compare(input string tag);
    bit eV, eF;
    int eS;
    eV = mRd < mStamps.size();
    eS = eV ? mStamps[mRd] : 0;
    eF = mStamps.size() > 0;
    checks++;
    if (stampValid !== eV || int'(stampOut) != eS || hitFlag !== eF || overflow !== mOvf) begin
      errors++;
      $display("FAIL %s: got v=%0b s=%0d f=%0b o=%0b exp v=%0b s=%0d f=%0b o=%0b",
               tag, stampValid, stampOut, hitFlag, overflow, eV, eS, eF, mOvf);
    end
  endtask

  // check outputs of the previous cycle, then drive and advance the model
  task automatic step(input string tag, input bit ts, input bit ta, input bit d, input bit rs);
    bit rise, unread;
    @(negedge clk);
    compare(tag);
    trainStart = ts; trainActive = ta; discIn = d; readStrobe = rs;
    xingCount = SW'(xcnt);
    rise = d && !mPrev;
    if (ts) begin
      mStamps.delete(); mRd = 0; mOvf = 0;
    end else begin
      unread = mRd < mStamps.size();
      if (rs && unread) mRd++;
      if (ta && rise) begin
        if (mStamps.size() < SLOTS) mStamps.push_back(xcnt);
        else mOvf = 1;
      end
    end
    mPrev = d;
    xcnt = ts ? 0 : (xcnt + 1) % 3000;
  endtask

  task automatic pulse(input string tag, input bit ta);
    step(tag, 0, ta, 1, 0);
    step(tag, 0, ta, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R5 reset");
    rstN = 1'b1;

    step("R5 start", 1, 0, 0, 0);
    repeat (7) step("R1 gap", 0, 1, 0, 0);
    pulse("R1 first", 1);
    repeat (20) step("R1 gap", 0, 1, 0, 0);
    pulse("R1 second", 1);
    repeat (5) step("R2 held", 0, 1, 1, 0);
    step("R2 low", 0, 1, 0, 0);
    pulse("R4 fourth", 1);
    pulse("R3 fifth", 1);
    pulse("R3 sixth", 1);
    step("R6 close", 0, 0, 0, 0);
    pulse("R6 outside", 0);
    for (int k = 0; k < 6; k++) step("R7 read", 0, 0, 0, 1);
    step("R8 read empty", 0, 0, 0, 1);
    step("R8 idle", 0, 0, 0, 0);

    step("R5 start", 1, 0, 0, 0);
    pulse("R6 outside", 0);
    step("R9 open", 0, 1, 0, 0);
    step("R9 empty strobe", 0, 1, 1, 1);
    step("R9 low", 0, 1, 0, 0);
    step("R9 both", 0, 1, 1, 1);
    step("R9 low", 0, 1, 0, 0);
    step("R9 both", 0, 1, 1, 1);
    step("R9 tail", 0, 1, 0, 0);
    step("R5 precedence", 1, 1, 1, 1);
    step("R5 after", 0, 1, 0, 1);

    for (int k = 0; k < 4000; k++) begin
      bit ts, ta, d, rs;
      ts = ($urandom % 97) == 0;
      ta = ($urandom % 4) != 0;
      d  = ($urandom % 3) == 0;
      rs = ($urandom % 3) == 0;
      step("R9 random", ts, ta, d, rs);
    end
    @(negedge clk);
    compare("R7 final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule